// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between an internal single-word request stream and an external byte-wide asynchronous static RAM. Each accepted request becomes one complete strobe sequence on the memory pins. The address is put out and the chip is selected, the read or write strobe is held for a number of clock cycles set by parameters, and the chip is then deselected again so the memory drops into standby between accesses. A read returns its byte to the internal side as a one-cycle response pulse.

Requests use a valid/ready handshake. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` stays low for the whole access, so the requester sees back-pressure for as long as the strobe sequence lasts. While `req_ready` is low, the request fields are ignored and may change freely. The response side has no ready signal. The consumer must take `rsp_rdata` in the single cycle that `rsp_valid` is high.

The write strobe controls every write, and output enable stays high throughout a write. The controller turns on its own data drivers only after the write strobe has been low for a set number of cycles. This gives the memory time to release the bus. The drivers are released one cycle after the write strobe rises, which provides the data hold time.

Top module: `sram_ctl`

## Requirements
- R1: Out of reset, and in every idle cycle, chip enable, write enable and output enable are all high (inactive), the data drivers are off and `req_ready` is high.
- R2: A request is accepted only on a clock edge with `req_valid` and `req_ready` both high. `req_ready` is low from the cycle after acceptance until the access finishes. Request fields presented while `req_ready` is low have no effect on the memory pins or on the data written.
- R3: A read holds chip enable low and write enable high. Output enable is high for the first `SETUP_CYC` cycles and low for the next `RD_CYC` cycles. The data bus is sampled at the end of the last of these cycles.
- R4: A write holds chip enable low. Write enable is high for the first `SETUP_CYC` cycles and then low for exactly `WR_CYC` cycles. Output enable stays high for the whole write, and write enable and output enable are never low together.
- R5: While chip enable is low, the memory address does not change, and it equals the address of the accepted request.
- R6: During a write, `mem_dq_oe` is low in the first cycle that write enable is low. It goes high only once write enable has been low for `DRIVE_LAG_CYC` cycles, and it falls one cycle after write enable rises. While `mem_dq_oe` is high, `mem_dq_out` holds the accepted write byte unchanged.
- R7: `mem_dq_oe` is never high while output enable is low or chip enable is high.
- R8: After each access the controller returns to idle with chip enable high. `req_ready` is high again `SETUP_CYC+RD_CYC+1` cycles after a read is accepted, and `SETUP_CYC+WR_CYC+2` cycles after a write is accepted.
- R9: `rsp_valid` is a single-cycle pulse. It appears `SETUP_CYC+RD_CYC+1` cycles after a read is accepted, and never for a write.
- R10: A read returns, on `rsp_rdata`, the byte most recently written to that address. An address that has never been written reads as 0 in the bench memory model.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 19 | Memory address pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | 8 | Data read from the memory pins |

## Verification
The hardest behaviour to reach from the ports is the ignore rule. A requester that keeps `req_valid` high and changes address and data in the middle of an access must not disturb the address pins or the byte written. The same holds across back-to-back writes, where the address may change only while chip enable is high. The stimulus keeps `req_valid` asserted and scrambles the request fields on every busy cycle. It also issues operations with no gap, so each new address lands right after deselect. A memory model flags any address change under both strobes, and any write whose data is not driven across the rising edge. Directed cases cover the lowest and highest addresses, overwrites and reads of unwritten locations.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_RECOV = 3'd4
  } seq_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
// Down counter for the wait states: loaded when a phase starts, reports zero on the phase's last cycle.
module sram_ctl_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sram_ctl_seq.sv
// Access sequencer: walks setup, strobe and recovery phases and decodes the pin levels.
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int SETUP_CYC     = 2,
  parameter int RD_CYC        = 3,
  parameter int WR_CYC        = 4,
  parameter int DRIVE_LAG_CYC = 1,
  parameter int CNT_W         = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic             req_write,
  input  logic [CNT_W-1:0] tmr_cnt,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             idle,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             drive,
  output logic             capture
);

  localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] READ_LD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WRITE_LD  = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] DRV_LIMIT = CNT_W'(WR_CYC - 1 - DRIVE_LAG_CYC);

  seq_state_t state_q, state_d;
  logic       is_wr_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = SETUP_LD;
    unique case (state_q)
      ST_IDLE: begin
        if (req_fire) begin
          state_d  = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = SETUP_LD;
        end
      end
      ST_SETUP: begin
        if (tmr_zero) begin
          tmr_load = 1'b1;
          if (is_wr_q) begin
            state_d = ST_WRITE;
            tmr_val = WRITE_LD;
          end else begin
            state_d = ST_READ;
            tmr_val = READ_LD;
          end
        end
      end
      ST_READ: begin
        if (tmr_zero) state_d = ST_IDLE;
      end
      ST_WRITE: begin
        if (tmr_zero) state_d = ST_RECOV;
      end
      ST_RECOV: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      is_wr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (req_fire && state_q == ST_IDLE) is_wr_q <= req_write;
    end
  end

  // Pin levels decode straight from the state register (one compare each).
  assign idle    = (state_q == ST_IDLE);
  assign ce_n    = (state_q == ST_IDLE);
  assign we_n    = (state_q != ST_WRITE);
  assign oe_n    = (state_q != ST_READ);
  assign capture = (state_q == ST_READ) && tmr_zero;
  assign drive   = ((state_q == ST_WRITE) && (tmr_cnt <= DRV_LIMIT)) ||
                   (state_q == ST_RECOV);

endmodule

// File: rtl/sram_ctl_dpath.sv
// Address/data holding registers and read capture.
module sram_ctl_dpath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (req_fire) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int SETUP_CYC     = 2,
  parameter int RD_CYC        = 3,
  parameter int WR_CYC        = 4,
  parameter int DRIVE_LAG_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int MAX_CYC = max3(SETUP_CYC, RD_CYC, WR_CYC);
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic             req_fire;
  logic             tmr_load, tmr_zero, idle, capture;
  logic [CNT_W-1:0] tmr_val, tmr_cnt;

  assign req_ready = idle;
  assign req_fire  = req_valid && idle;

  sram_ctl_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .cnt      (tmr_cnt),
    .zero     (tmr_zero)
  );

  sram_ctl_seq #(
    .SETUP_CYC     (SETUP_CYC),
    .RD_CYC        (RD_CYC),
    .WR_CYC        (WR_CYC),
    .DRIVE_LAG_CYC (DRIVE_LAG_CYC),
    .CNT_W         (CNT_W)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_fire  (req_fire),
    .req_write (req_write),
    .tmr_cnt   (tmr_cnt),
    .tmr_zero  (tmr_zero),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .idle      (idle),
    .ce_n      (mem_ce_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .drive     (mem_dq_oe),
    .capture   (capture)
  );

  sram_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_fire   (req_fire),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .capture    (capture),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  assert_drive_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !mem_dq_oe);

  assert_drive_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe ##1 !mem_dq_oe));

  assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_ctl_tb_top.sv
module sram_ctl_tb_top;

  localparam int SU = 2;
  localparam int RD = 3;
  localparam int WR = 4;
  localparam int LAG = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  rsp_rdata, mem_dq_out, mem_dq_in;
  logic [18:0] mem_addr;

  int n_chk = 0, n_bad = 0, cyc_total = 0;
  logic [7:0] sram_q [int];   // memory model contents
  logic [7:0] ref_q  [int];   // bench scoreboard

  always #4 clk = ~clk;  // 125 MHz

  sram_ctl #(.SETUP_CYC(SU), .RD_CYC(RD), .WR_CYC(WR), .DRIVE_LAG_CYC(LAG)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sram_rd(input logic [18:0] a);
    return sram_q.exists(int'(a)) ? sram_q[int'(a)] : 8'h00;
  endfunction

  function automatic logic [7:0] ref_rd(input logic [18:0] a);
    return ref_q.exists(int'(a)) ? ref_q[int'(a)] : 8'h00;
  endfunction

  // Memory model: drives data when selected with output enable low.
  always @* begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n) mem_dq_in = sram_rd(mem_addr);
    else                                     mem_dq_in = 8'h5A;
  end

  logic        p_ce = 1'b1, p_we = 1'b1, p_oe_dq = 1'b0;
  logic [18:0] p_addr = '0;
  logic [7:0]  p_dq = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!p_ce && !p_we && !mem_ce_n && !mem_we_n)
        chk(mem_addr == p_addr, "R5 address moved under both strobes", int'(mem_addr), int'(p_addr));
      if (mem_dq_oe)
        chk(mem_oe_n && !mem_ce_n, "R7 drive while memory may drive", int'(mem_oe_n), 1);
      if (!p_ce && !p_we && (mem_we_n || mem_ce_n)) begin
        chk(p_oe_dq && mem_dq_oe && (mem_dq_out == p_dq),
            "R6 write data not stable through strobe rise", int'(mem_dq_out), int'(p_dq));
        sram_q[int'(p_addr)] = p_dq;
      end
    end
    p_ce = mem_ce_n; p_we = mem_we_n; p_oe_dq = mem_dq_oe; p_addr = mem_addr; p_dq = mem_dq_out;
  end

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc_total);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // One access; entered at a negedge where req_ready is high.
  task automatic run_op(input bit wr, input logic [18:0] a, input logic [7:0] d);
    int cyc = 0, we_low = 0, oe_low = 0, rsp_cnt = 0, rsp_at = 0, addr_bad = 0;
    bit done = 0;
    logic [7:0] exp_rd, got;
    exp_rd = ref_rd(a);
    got = 8'h00;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    if (wr) ref_q[int'(a)] = d;
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (req_ready) begin
        done = 1;
        req_valid = 1'b0;
      end else begin
        // busy: keep presenting junk that must be ignored (R2)
        req_valid = ($urandom_range(0, 3) != 0);
        req_write = $urandom_range(0, 1) == 1;
        req_addr  = 19'($urandom);
        req_wdata = 8'($urandom);
      end
      if (!mem_ce_n && mem_addr != a) addr_bad++;
      if (!mem_we_n) we_low++;
      if (!mem_oe_n) oe_low++;
      if (rsp_valid) begin rsp_cnt++; rsp_at = cyc; got = rsp_rdata; end
      if (cyc > 40) done = 1;
    end
    chk(addr_bad == 0, "R5 address differs from request while selected", addr_bad, 0);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 idle pins after access",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    if (wr) begin
      chk(cyc == SU + WR + 2, "R8 write busy length", cyc, SU + WR + 2);
      chk(we_low == WR, "R4 write strobe width", we_low, WR);
      chk(oe_low == 0, "R4 output enable during write", oe_low, 0);
      chk(rsp_cnt == 0, "R9 response after write", rsp_cnt, 0);
      chk(sram_rd(a) == d, "R2 byte stored in memory", int'(sram_rd(a)), int'(d));
    end else begin
      chk(cyc == SU + RD + 1, "R8 read busy length", cyc, SU + RD + 1);
      chk(oe_low == RD, "R3 output enable width", oe_low, RD);
      chk(we_low == 0, "R3 write strobe during read", we_low, 0);
      chk(rsp_cnt == 1 && rsp_at == SU + RD + 1, "R9 response pulse timing", rsp_at, SU + RD + 1);
      chk(got == exp_rd, "R10 read data", int'(got), int'(exp_rd));
    end
  endtask

  function automatic logic [18:0] pick_addr();
    int k;
    k = $urandom_range(0, 17);
    if (k == 16) return 19'h00000;
    if (k == 17) return 19'h7FFFF;
    return 19'h12340 + 19'(k * 3);
  endfunction

  initial begin
    void'($urandom(32'h5EED_0C7A));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
        "R1 reset state", {req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}, 6'b111100);

    // directed corners
    run_op(1'b0, 19'h00055, 8'h00);              // unwritten location reads 0 (R10)
    run_op(1'b1, 19'h00000, 8'h3C);
    run_op(1'b1, 19'h7FFFF, 8'hC3);
    run_op(1'b0, 19'h00000, 8'h00);
    run_op(1'b0, 19'h7FFFF, 8'h00);
    run_op(1'b1, 19'h00100, 8'hAA);               // back-to-back overwrite
    run_op(1'b1, 19'h00100, 8'h55);
    run_op(1'b0, 19'h00100, 8'h00);
    run_op(1'b1, 19'h00101, 8'hFF);               // back-to-back writes, new address
    run_op(1'b1, 19'h00102, 8'h01);
    run_op(1'b0, 19'h00101, 8'h00);
    run_op(1'b0, 19'h00102, 8'h00);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int gap;
      gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk(!rsp_valid || g == 0, "R9 stray response in idle", int'(rsp_valid), 0);
      end
      run_op($urandom_range(0, 1) == 1, pick_addr(), 8'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule